// File: doc/BRIEF.md
# Two-Stage Accumulator Processor Core

This block is a small 32-bit processor built around a single accumulator. A program counter walks a 256-word internal memory. Each fetched word goes into an instruction register, and the instruction held there executes in the following cycle. Fetch and execute overlap, so a straight run of instructions completes one instruction per clock. The only change of flow is an unconditional jump, which flushes the pipeline. There are no interrupts and no conditional branches, and all data is treated as unsigned.

Memory reads and writes share one internal data path. A buffer drives the accumulator onto that path only while a store executes. At every other time the path carries the word read from memory.

A preload port fills the memory while the core is held in reset. The accumulator, the program counter and a halt flag are brought out so that a program's result can be observed.

Top module: `acc_cpu_core`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the core clears the program counter, the accumulator and the halt flag and empties the pipeline. Asserting `mem_load_en` writes `mem_load_data` into word `mem_load_addr`, and this works while the core is held in reset.
- R2: An instruction word is laid out as follows. Bits 31:28 hold the opcode. Bit 27 selects the operand mode: 0 means memory and 1 means register. Bits 7:0 give the memory word address. Bits 26:8 have no effect.
- R3: The arithmetic opcodes use operand `d` and wrap modulo 2^32. Opcode 0000 computes acc+d, 0001 computes acc-d, 0010 computes d+1 and 0011 computes d-1.
- R4: The logic opcodes use operand `d`. Opcode 0100 computes acc AND d, 0101 computes acc OR d, 0110 computes acc XOR d, 0111 computes NOT d, 1000 shifts d left by one and 1001 shifts d right by one (logical shift, zero fill).
- R5: Opcode 1010 loads the addressed memory word into the accumulator. Opcode 1011 writes the accumulator to the addressed word and leaves every other word unchanged.
- R6: In register mode (bit 27 set), the operand `d` of opcodes 0000 to 1001 is the accumulator itself instead of the memory word.
- R7: Fetch and execute overlap. A program of N non-halt instructions followed by a halt raises `halted` N+2 rising edges after reset is released.
- R8: Opcode 1100 sets the program counter to the address field. The word after the jump is never executed, and the jump costs exactly one extra cycle.
- R9: Opcode 1101 sets `halted`. The program counter then holds the halt's address plus one, and the accumulator and program counter stay frozen until the next reset.
- R10: Opcodes 1110 and 1111 leave the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_load_en | input | 1 | Preload write strobe |
| mem_load_addr | input | 8 | Preload word address |
| mem_load_data | input | 32 | Preload word |
| acc_out | output | 32 | Accumulator value |
| pc_out | output | 8 | Program counter value |
| halted | output | 1 | Set once a halt has executed |

## Verification
The bench goes after the wrap points of the arithmetic, such as an add that passes 2^32, an increment of all-ones and a decrement of zero. It also drives patterns where the top bit crosses a shift boundary, so a design that sign-extends or drops carries returns the wrong accumulator. A jump placed in front of a word that would change the result exposes a core that executes the word it should discard, and the cycle count exposes one that stalls too long or too little. Two programs probe the memory path. One reads a stored word back through the shared path, and the other reads a neighbouring word, which catches a design that writes at the wrong time or to the wrong place. Further tests fill the ignored bits with junk, check that no-operations leave the accumulator alone, and check that the core stays frozen after a halt.

// File: rtl/acc_cpu_pkg.sv
// Shared opcode encoding and decoded control bundle for the accumulator core.
// Assumes a fixed 4-bit opcode at the top of every instruction word.
package acc_cpu_pkg;
    localparam int OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_ADD   = 4'h0,
        OP_SUB   = 4'h1,
        OP_INC   = 4'h2,
        OP_DEC   = 4'h3,
        OP_AND   = 4'h4,
        OP_OR    = 4'h5,
        OP_XOR   = 4'h6,
        OP_NOT   = 4'h7,
        OP_SHL   = 4'h8,
        OP_SHR   = 4'h9,
        OP_LOAD  = 4'hA,
        OP_STORE = 4'hB,
        OP_JUMP  = 4'hC,
        OP_HALT  = 4'hD,
        OP_NOP0  = 4'hE,
        OP_NOP1  = 4'hF
    } opcode_e;

    typedef struct packed {
        logic acc_we;    // result goes to the accumulator
        logic mem_we;    // accumulator goes to memory
        logic jump;      // unconditional transfer
        logic halt;      // stop fetching for good
        logic reg_mode;  // operand is the accumulator
    } ctrl_t;
endpackage

// File: rtl/acc_cpu_mem.sv
// Word memory with one write port and two combinational read ports.
// Port A serves instruction fetch, port B serves the execute operand.
// Assumes a write and a read of the same word in one cycle returns the old word.
module acc_cpu_mem #(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] words [DEPTH];

    // Write one word per cycle when enabled.
    always_ff @(posedge clk) begin
        if (we) begin
            words[waddr] <= wdata;
        end
    end

    // Both read ports are plain lookups.
    assign rdata_a = words[raddr_a];
    assign rdata_b = words[raddr_b];
endmodule

// File: rtl/acc_cpu_decode.sv
// Opcode decoder: maps the opcode and mode bit to the control bundle.
// Assumes the caller gates the bundle with the execute-valid condition.
module acc_cpu_decode
    import acc_cpu_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    input  logic             mode_bit,
    output ctrl_t            ctrl
);
    // Translate each opcode into its control actions.
    always_comb begin
        ctrl = '0;
        case (opcode_e'(opc))
            OP_ADD, OP_SUB, OP_INC, OP_DEC, OP_AND, OP_OR, OP_XOR,
            OP_NOT, OP_SHL, OP_SHR: begin
                ctrl.acc_we   = 1'b1;
                ctrl.reg_mode = mode_bit;
            end
            OP_LOAD:  ctrl.acc_we = 1'b1;
            OP_STORE: ctrl.mem_we = 1'b1;
            OP_JUMP:  ctrl.jump   = 1'b1;
            OP_HALT:  ctrl.halt   = 1'b1;
            default:  ctrl = '0;
        endcase
    end
endmodule

// File: rtl/acc_cpu_alu.sv
// Unsigned arithmetic and logic unit. Combines the accumulator with the operand.
// Assumes a load passes the operand through and other non-ALU opcodes keep the accumulator.
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int DW = 32
) (
    input  opcode_e       op,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] opnd,
    output logic [DW-1:0] res
);
    localparam logic [DW-1:0] ONE = DW'(1);

    // Select the result for the current opcode.
    always_comb begin
        case (op)
            OP_ADD:  res = acc + opnd;
            OP_SUB:  res = acc - opnd;
            OP_INC:  res = opnd + ONE;
            OP_DEC:  res = opnd - ONE;
            OP_AND:  res = acc & opnd;
            OP_OR:   res = acc | opnd;
            OP_XOR:  res = acc ^ opnd;
            OP_NOT:  res = ~opnd;
            OP_SHL:  res = {opnd[DW-2:0], 1'b0};
            OP_SHR:  res = {1'b0, opnd[DW-1:1]};
            OP_LOAD: res = opnd;
            default: res = acc;
        endcase
    end
endmodule

// File: rtl/acc_cpu_bus.sv
// Shared data path buffer. Puts the accumulator on the path only during a store;
// otherwise the path carries the memory read word.
// Assumes a single driver enable from the execute stage.
module acc_cpu_bus #(
    parameter int DW = 32
) (
    input  logic          drive_en,
    input  logic [DW-1:0] acc_val,
    input  logic [DW-1:0] mem_val,
    output logic [DW-1:0] bus_val
);
    // Choose the direction of the shared path.
    always_comb begin
        bus_val = drive_en ? acc_val : mem_val;
    end
endmodule

// File: rtl/acc_cpu_core.sv
// Two-stage accumulator processor: fetch of the next word overlaps execution
// of the current one. A jump squashes the fetch slot and a halt freezes the core.
// Assumes the preload port is used while reset is held; it wins over a store.
module acc_cpu_core
    import acc_cpu_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mem_load_en,
    input  logic [AW-1:0] mem_load_addr,
    input  logic [DW-1:0] mem_load_data,
    output logic [DW-1:0] acc_out,
    output logic [AW-1:0] pc_out,
    output logic          halted
);
    localparam int MODE_POS = DW - OPC_W - 1;
    localparam logic [AW-1:0] PC_STEP = AW'(1);

    logic [AW-1:0]    pc_q;
    logic [DW-1:0]    ir_q;
    logic             ir_valid_q;
    logic [DW-1:0]    acc_q;
    logic             halted_q;

    logic [OPC_W-1:0] ir_opc;
    logic [AW-1:0]    ir_addr;
    ctrl_t            ctrl;
    logic             ex_v;
    logic             redirect;
    logic             fetch_en;
    logic [DW-1:0]    fetch_word;
    logic [DW-1:0]    mem_word;
    logic [DW-1:0]    bus_val;
    logic [DW-1:0]    operand;
    logic [DW-1:0]    alu_res;
    logic             mem_we;
    logic [AW-1:0]    mem_waddr;
    logic [DW-1:0]    mem_wdata;

    assign ir_opc   = ir_q[DW-1 -: OPC_W];
    assign ir_addr  = ir_q[AW-1:0];
    assign ex_v     = ir_valid_q && !halted_q;
    assign redirect = ex_v && (ctrl.jump || ctrl.halt);
    assign fetch_en = !halted_q && !redirect;

    acc_cpu_decode u_decode (
        .opc      (ir_opc),
        .mode_bit (ir_q[MODE_POS]),
        .ctrl     (ctrl)
    );

    acc_cpu_mem #(.DW(DW), .AW(AW)) u_mem (
        .clk     (clk),
        .we      (mem_we),
        .waddr   (mem_waddr),
        .wdata   (mem_wdata),
        .raddr_a (pc_q),
        .rdata_a (fetch_word),
        .raddr_b (ir_addr),
        .rdata_b (mem_word)
    );

    acc_cpu_bus #(.DW(DW)) u_bus (
        .drive_en (ex_v && ctrl.mem_we),
        .acc_val  (acc_q),
        .mem_val  (mem_word),
        .bus_val  (bus_val)
    );

    assign operand = ctrl.reg_mode ? acc_q : bus_val;

    acc_cpu_alu #(.DW(DW)) u_alu (
        .op   (opcode_e'(ir_opc)),
        .acc  (acc_q),
        .opnd (operand),
        .res  (alu_res)
    );

    // Memory write source: the preload port first, then a store in execute.
    always_comb begin
        mem_we    = mem_load_en || (ex_v && ctrl.mem_we);
        mem_waddr = mem_load_en ? mem_load_addr : ir_addr;
        mem_wdata = mem_load_en ? mem_load_data : bus_val;
    end

    // Fetch stage: program counter and instruction register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q       <= '0;
            ir_q       <= '0;
            ir_valid_q <= 1'b0;
        end else if (ex_v && ctrl.jump) begin
            pc_q       <= ir_addr;
            ir_valid_q <= 1'b0;
        end else if (fetch_en) begin
            ir_q       <= fetch_word;
            ir_valid_q <= 1'b1;
            pc_q       <= pc_q + PC_STEP;
        end else begin
            ir_valid_q <= 1'b0;
        end
    end

    // Execute stage: accumulator update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (ex_v && ctrl.acc_we) begin
            acc_q <= alu_res;
        end
    end

    // Halt flag: set by a halt and kept until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halted_q <= 1'b0;
        end else if (ex_v && ctrl.halt) begin
            halted_q <= 1'b1;
        end
    end

    assign acc_out = acc_q;
    assign pc_out  = pc_q;
    assign halted  = halted_q;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (pc_q == '0 && acc_q == '0 && !halted_q && !ir_valid_q)); // R1

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted_q && !(ir_valid_q && (ir_opc == OP_JUMP || ir_opc == OP_HALT)))
        |=> (pc_q == $past(pc_q) + PC_STEP)); // R7

    AST_JUMP_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_valid_q && !halted_q && ir_opc == OP_JUMP)
        |=> (!ir_valid_q && pc_q == $past(ir_addr))); // R8

    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        halted_q |=> (halted_q && $stable(acc_q) && $stable(pc_q))); // R9

    AST_NOP_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_valid_q && (ir_opc == OP_NOP0 || ir_opc == OP_NOP1))
        |=> $stable(acc_q)); // R10
endmodule

// File: tb/acc_cpu_core_bench.sv
module acc_cpu_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_load_en = 1'b0;
    logic [7:0]  mem_load_addr = '0;
    logic [31:0] mem_load_data = '0;
    logic [31:0] acc_out;
    logic [7:0]  pc_out;
    logic        halted;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    acc_cpu_core u_acc_cpu_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .mem_load_en   (mem_load_en),
        .mem_load_addr (mem_load_addr),
        .mem_load_data (mem_load_data),
        .acc_out       (acc_out),
        .pc_out        (pc_out),
        .halted        (halted)
    );

    function automatic logic [31:0] ins(logic [3:0] op, logic mode, logic [7:0] addr);
        return {op, mode, 19'h0, addr};
    endfunction

    function automatic logic [31:0] model(logic [3:0] op, logic mode,
                                          logic [31:0] a, logic [31:0] m);
        logic [31:0] d;
        d = mode ? a : m;
        case (op)
            4'h0: return a + d;
            4'h1: return a - d;
            4'h2: return d + 32'd1;
            4'h3: return d - 32'd1;
            4'h4: return a & d;
            4'h5: return a | d;
            4'h6: return a ^ d;
            4'h7: return ~d;
            4'h8: return d << 1;
            4'h9: return d >> 1;
            default: return a;
        endcase
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
    endtask

    task automatic put(logic [7:0] a, logic [31:0] w);
        @(negedge clk);
        mem_load_en   = 1'b1;
        mem_load_addr = a;
        mem_load_data = w;
        @(posedge clk);
    endtask

    task automatic run(output int cyc);
        @(negedge clk);
        mem_load_en = 1'b0;
        rst_n       = 1'b1;
        cyc = 0;
        for (int i = 0; i < 200; i++) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (halted) break;
        end
    endtask

    task automatic t_reset();
        hold_reset();
        @(negedge clk);
        chk("R1", "acc in reset", acc_out, 32'h0);
        chk("R1", "pc in reset", {24'h0, pc_out}, 32'h0);
        chk("R1", "halted in reset", {31'h0, halted}, 32'h0);
    endtask

    // Program: load a, apply op to word 0x81 (d), halt at address 2.
    task automatic run_one(string req, logic [3:0] op, logic mode,
                           logic [31:0] a, logic [31:0] d, logic [18:0] junk);
        int cyc;
        hold_reset();
        put(8'h00, ins(4'hA, 1'b0, 8'h80));
        put(8'h01, ins(op, mode, 8'h81) | {5'h0, junk, 8'h0});
        put(8'h02, ins(4'hD, 1'b0, 8'h00));
        put(8'h80, a);
        put(8'h81, d);
        run(cyc);
        chk(req, $sformatf("op %h mode %0d result", op, mode), acc_out, model(op, mode, a, d));
        chk("R7", "straight cycles to halt", cyc, 4);
        chk("R9", "pc after halt at 2", {24'h0, pc_out}, 32'h3);
    endtask

    task automatic t_arith();
        run_one("R3", 4'h0, 1'b0, 32'hFFFF_FFF0, 32'h0000_0020, '0);
        run_one("R3", 4'h1, 1'b0, 32'h0000_0005, 32'h0000_0007, '0);
        run_one("R3", 4'h2, 1'b0, 32'h1234_0000, 32'hFFFF_FFFF, '0);
        run_one("R3", 4'h3, 1'b0, 32'h1234_0000, 32'h0000_0000, '0);
    endtask

    task automatic t_logic();
        run_one("R4", 4'h4, 1'b0, 32'hF0F0_AAAA, 32'hFF00_5555, '0);
        run_one("R4", 4'h5, 1'b0, 32'hF0F0_0000, 32'h0F00_1234, '0);
        run_one("R4", 4'h6, 1'b0, 32'hDEAD_BEEF, 32'hFFFF_0000, '0);
        run_one("R4", 4'h7, 1'b0, 32'h0000_0000, 32'h0F0F_0F0F, '0);
        run_one("R4", 4'h8, 1'b0, 32'h0000_0000, 32'h8000_0001, '0);
        run_one("R4", 4'h9, 1'b0, 32'h0000_0000, 32'h8000_0001, '0);
    endtask

    task automatic t_mode();
        run_one("R6", 4'h0, 1'b1, 32'h1234_5678, 32'h0000_0001, '0);
        run_one("R6", 4'h7, 1'b1, 32'h00FF_00FF, 32'h0000_0000, '0);
        run_one("R6", 4'h9, 1'b1, 32'h8000_0000, 32'h0000_0000, '0);
    endtask

    task automatic t_format_nop();
        run_one("R2", 4'h0, 1'b0, 32'h0000_0100, 32'h0000_0023, 19'h5A5A5);
        run_one("R10", 4'hE, 1'b0, 32'hA5A5_0001, 32'h0000_0077, '0);
        run_one("R10", 4'hF, 1'b1, 32'hA5A5_0002, 32'h0000_0077, '0);
    endtask

    task automatic t_mem();
        int cyc;
        hold_reset();
        put(8'h00, ins(4'hA, 1'b0, 8'h80));
        put(8'h01, ins(4'hB, 1'b0, 8'h90));
        put(8'h02, ins(4'hA, 1'b0, 8'h81));
        put(8'h03, ins(4'hA, 1'b0, 8'h90));
        put(8'h04, ins(4'hD, 1'b0, 8'h00));
        put(8'h80, 32'hCAFE_BABE);
        put(8'h81, 32'h0000_0001);
        put(8'h90, 32'h0000_0000);
        run(cyc);
        chk("R5", "store then load back", acc_out, 32'hCAFE_BABE);
        chk("R7", "four-instruction cycles", cyc, 6);
        hold_reset();
        put(8'h02, ins(4'hA, 1'b0, 8'h91));
        put(8'h03, ins(4'hD, 1'b0, 8'h00));
        put(8'h91, 32'h0BAD_F00D);
        run(cyc);
        chk("R5", "neighbour word untouched by store", acc_out, 32'h0BAD_F00D);
    endtask

    task automatic t_jump();
        int cyc;
        hold_reset();
        put(8'h00, ins(4'hA, 1'b0, 8'h80));
        put(8'h01, ins(4'hC, 1'b0, 8'h04));
        put(8'h02, ins(4'h2, 1'b0, 8'h80));
        put(8'h03, ins(4'h2, 1'b0, 8'h80));
        put(8'h04, ins(4'h0, 1'b0, 8'h81));
        put(8'h05, ins(4'hD, 1'b0, 8'h00));
        put(8'h80, 32'd7);
        put(8'h81, 32'd3);
        run(cyc);
        chk("R8", "skipped words not executed", acc_out, 32'd10);
        chk("R8", "jump bubble cycle count", cyc, 6);
        chk("R9", "pc after halt at 5", {24'h0, pc_out}, 32'h6);
    endtask

    task automatic t_halt_hold();
        logic [31:0] acc_h;
        logic [7:0]  pc_h;
        run_one("R3", 4'h0, 1'b0, 32'h0000_0011, 32'h0000_0022, '0);
        acc_h = acc_out;
        pc_h  = pc_out;
        repeat (6) @(negedge clk);
        chk("R9", "acc frozen after halt", acc_out, acc_h);
        chk("R9", "pc frozen after halt", {24'h0, pc_out}, {24'h0, pc_h});
        chk("R9", "halted stays set", {31'h0, halted}, 32'h1);
        t_reset();
    endtask

    initial begin
        t_reset();
        t_arith();
        t_logic();
        t_mode();
        t_format_nop();
        t_mem();
        t_jump();
        t_halt_hold();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule